// File: doc/BRIEF.md
# Cache Way Shrink/Expand Controller

This block decides how many ways of a 16-way last-level cache are powered. When the power controller reports low activity, it retires every way except the two lowest. Each retired way is handled in turn. Its allocation enable is removed first. The external flush engine is then asked to write the way back. Once that flush completes, the way is put to sleep. When all retired ways are asleep, the block signals that the cache supply may be lowered, by about 30 mV.

A high-activity indication restores the full cache. The reduced-voltage permission is withdrawn first. All sleeping ways are then woken together, and after a fixed settle delay they are re-enabled for allocation. No flush is needed in this direction. A high-activity indication that arrives partway through a shrink is remembered. It is acted on as soon as the way currently being flushed has finished, and the block then reverses into an expand.

Top module: `way_shrink_ctrl`

## Requirements
- R1: While reset is asserted and after its release, way_en_o is 0xFFFF, way_sleep_o is 0x0000, flush_req_o is 0x0000, and busy_o and lowv_ok_o are 0.
- R2: In the full state, low_act_i with high_act_i low starts a shrink. If both are high in the same cycle, nothing happens. Bits 0 and 1 of way_en_o always stay 1 and are never flushed or put to sleep.
- R3: Ways 2 through 15 are flushed in ascending order. flush_req_o has at most one bit set, and that bit is the bit of the way being flushed. It stays set until flush_done_i.
- R4: A way's bit in way_en_o falls one cycle before its bit in flush_req_o rises.
- R5: The clock edge that samples flush_done_i high clears flush_req_o and sets that way's bit in way_sleep_o. The next way's enable bit falls on the same edge.
- R6: lowv_ok_o rises on the edge where way 15 goes to sleep. From then on way_en_o is 0x0003, way_sleep_o is 0xFFFC and busy_o is 0.
- R7: In the shrunk state, high_act_i clears lowv_ok_o on the next edge. way_sleep_o clears to 0x0000 one edge later.
- R8: way_en_o returns to 0xFFFF exactly SETTLE_CYCLES edges after way_sleep_o clears, and busy_o falls on that same edge.
- R9: If high_act_i arrives during a shrink, it is held. The current way's flush completes and the way sleeps. No further way is disabled or flushed, lowv_ok_o stays 0, and the expand sequence of R7 and R8 follows.
- R10: flush_done_i is ignored while no flush is requested. low_act_i is ignored in the shrunk state and during an expand. high_act_i is ignored in the full state.
- R11: busy_o is 1 in every state except full and shrunk. lowv_ok_o and busy_o are never both 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| low_act_i | input | 1 | Low-activity indication; starts a shrink |
| high_act_i | input | 1 | High-activity indication; starts an expand or reverses a shrink |
| flush_done_i | input | 1 | Flush engine reports that the requested way has been flushed |
| way_en_o | output | 16 | Allocation enable, one bit per way |
| way_sleep_o | output | 16 | Sleep control, one bit per way |
| flush_req_o | output | 16 | Flush request, at most one bit set |
| busy_o | output | 1 | A shrink or expand is in progress |
| lowv_ok_o | output | 1 | Cache supply may be lowered |

## Verification
The key collision is between a way's flush completion and an expand request. They can land in the same cycle, or the expand can arrive earlier while the flush is still outstanding. The bench provokes both cases. Random runs pick the reversal way and the timing of the collision. Directed runs cover the first way and the last way.

In each case it judges one edge and the edge after it. On the completion edge, the flushed way must sleep while the next way keeps its enable. On the following edge, every way must wake and no new flush request may appear. If the collision happens on way 15, the controller must reverse rather than grant reduced voltage.

// File: rtl/wsc_pkg.sv
package wsc_pkg;
  typedef enum logic [2:0] {
    ST_FULL,
    ST_CLR,
    ST_FLUSH,
    ST_SHRUNK,
    ST_VDROP,
    ST_SETTLE
  } wsc_state_e;
endpackage

// File: rtl/wsc_way_ptr.sv
module wsc_way_ptr #(
  parameter int NUM_WAYS  = 16,
  parameter int KEEP_WAYS = 2,
  parameter int IW        = $clog2(NUM_WAYS)
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                load_i,
  input  logic                adv_i,
  output logic [NUM_WAYS-1:0] cur_oh_o,
  output logic [NUM_WAYS-1:0] nxt_oh_o,
  output logic                last_o
);
  localparam logic [IW-1:0] FIRST_IDX = IW'(KEEP_WAYS);
  localparam logic [IW-1:0] LAST_IDX  = IW'(NUM_WAYS - 1);

  logic [IW-1:0] idx_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     idx_q <= FIRST_IDX;
    else if (load_i) idx_q <= FIRST_IDX;
    else if (adv_i)  idx_q <= idx_q + 1'b1;
  end

  assign last_o = (idx_q == LAST_IDX);

  always_comb begin
    cur_oh_o = '0;
    cur_oh_o[idx_q] = 1'b1;
    nxt_oh_o = '0;
    if (!last_o) nxt_oh_o[IW'(idx_q + 1'b1)] = 1'b1;
  end

  // R3
  ptr_no_wrap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    adv_i |-> !last_o);
endmodule

// File: rtl/wsc_mask_bank.sv
module wsc_mask_bank #(
  parameter int NUM_WAYS  = 16,
  parameter int KEEP_WAYS = 2
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [NUM_WAYS-1:0] dis_i,
  input  logic [NUM_WAYS-1:0] sleep_set_i,
  input  logic                wake_all_i,
  input  logic                en_all_i,
  output logic [NUM_WAYS-1:0] en_o,
  output logic [NUM_WAYS-1:0] sleep_o
);
  for (genvar g = 0; g < NUM_WAYS; g++) begin : g_way
    if (g < KEEP_WAYS) begin : g_kept
      assign en_o[g]    = 1'b1;
      assign sleep_o[g] = 1'b0;
      // R2
      kept_untouched_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !(dis_i[g] || sleep_set_i[g]));
    end else begin : g_ret
      logic en_q, sleep_q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
          en_q    <= 1'b1;
          sleep_q <= 1'b0;
        end else begin
          if (en_all_i)      en_q <= 1'b1;
          else if (dis_i[g]) en_q <= 1'b0;
          if (wake_all_i)          sleep_q <= 1'b0;
          else if (sleep_set_i[g]) sleep_q <= 1'b1;
        end
      end
      assign en_o[g]    = en_q;
      assign sleep_o[g] = sleep_q;
      // R5
      sleep_blocks_en_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        sleep_q |-> !en_q);
    end
  end
endmodule

// File: rtl/wsc_settle_timer.sv
module wsc_settle_timer #(
  parameter int SETTLE_CYCLES = 8,
  parameter int CW            = $clog2(SETTLE_CYCLES + 1)
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  output logic done_o
);
  localparam logic [CW-1:0] LAST_CNT = CW'(SETTLE_CYCLES - 1);

  logic          run_q;
  logic [CW-1:0] cnt_q;

  assign done_o = run_q && (cnt_q == LAST_CNT);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_q <= 1'b0;
      cnt_q <= '0;
    end else if (start_i) begin
      run_q <= 1'b1;
      cnt_q <= '0;
    end else if (done_o) begin
      run_q <= 1'b0;
    end else if (run_q) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  // R8
  settle_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
endmodule

// File: rtl/way_shrink_ctrl.sv
module way_shrink_ctrl
  import wsc_pkg::*;
#(
  parameter int NUM_WAYS      = 16,
  parameter int KEEP_WAYS     = 2,
  parameter int SETTLE_CYCLES = 8
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                low_act_i,
  input  logic                high_act_i,
  input  logic                flush_done_i,
  output logic [NUM_WAYS-1:0] way_en_o,
  output logic [NUM_WAYS-1:0] way_sleep_o,
  output logic [NUM_WAYS-1:0] flush_req_o,
  output logic                busy_o,
  output logic                lowv_ok_o
);
  localparam int IW = $clog2(NUM_WAYS);
  localparam logic [NUM_WAYS-1:0] KEEP_MASK   = NUM_WAYS'((64'd1 << KEEP_WAYS) - 64'd1);
  localparam logic [NUM_WAYS-1:0] RETIRE_MASK = ~KEEP_MASK;
  localparam logic [NUM_WAYS-1:0] FIRST_OH    = NUM_WAYS'(64'd1 << KEEP_WAYS);

  wsc_state_e          state_q, state_d;
  logic [NUM_WAYS-1:0] req_d;
  logic                lowv_d, pend_q, pend_d;
  logic                ptr_load, ptr_adv, last_way;
  logic [NUM_WAYS-1:0] cur_oh, nxt_oh, dis_vec, sleep_vec;
  logic                wake_all, en_all, tmr_start, tmr_done;

  wsc_way_ptr #(.NUM_WAYS(NUM_WAYS), .KEEP_WAYS(KEEP_WAYS), .IW(IW)) u_ptr (
    .clk_i, .rst_ni, .load_i(ptr_load), .adv_i(ptr_adv),
    .cur_oh_o(cur_oh), .nxt_oh_o(nxt_oh), .last_o(last_way)
  );

  wsc_mask_bank #(.NUM_WAYS(NUM_WAYS), .KEEP_WAYS(KEEP_WAYS)) u_bank (
    .clk_i, .rst_ni, .dis_i(dis_vec), .sleep_set_i(sleep_vec),
    .wake_all_i(wake_all), .en_all_i(en_all),
    .en_o(way_en_o), .sleep_o(way_sleep_o)
  );

  wsc_settle_timer #(.SETTLE_CYCLES(SETTLE_CYCLES)) u_tmr (
    .clk_i, .rst_ni, .start_i(tmr_start), .done_o(tmr_done)
  );

  always_comb begin
    state_d   = state_q;
    req_d     = flush_req_o;
    lowv_d    = lowv_ok_o;
    pend_d    = pend_q;
    ptr_load  = 1'b0;
    ptr_adv   = 1'b0;
    dis_vec   = '0;
    sleep_vec = '0;
    wake_all  = 1'b0;
    en_all    = 1'b0;
    tmr_start = 1'b0;
    unique case (state_q)
      ST_FULL: begin
        if (low_act_i && !high_act_i) begin
          ptr_load = 1'b1;
          dis_vec  = FIRST_OH;
          state_d  = ST_CLR;
        end
      end
      ST_CLR: begin
        // enable already dropped last edge; request flush now
        req_d   = cur_oh;
        state_d = ST_FLUSH;
        if (high_act_i) pend_d = 1'b1;
      end
      ST_FLUSH: begin
        if (high_act_i) pend_d = 1'b1;
        if (flush_done_i) begin
          req_d     = '0;
          sleep_vec = cur_oh;
          if (pend_q || high_act_i) begin
            pend_d  = 1'b0;
            state_d = ST_VDROP;
          end else if (last_way) begin
            lowv_d  = 1'b1;
            state_d = ST_SHRUNK;
          end else begin
            ptr_adv = 1'b1;
            dis_vec = nxt_oh;
            state_d = ST_CLR;
          end
        end
      end
      ST_SHRUNK: begin
        if (high_act_i) begin
          lowv_d  = 1'b0;
          state_d = ST_VDROP;
        end
      end
      ST_VDROP: begin
        wake_all  = 1'b1;
        tmr_start = 1'b1;
        state_d   = ST_SETTLE;
      end
      ST_SETTLE: begin
        if (tmr_done) begin
          en_all  = 1'b1;
          state_d = ST_FULL;
        end
      end
      default: state_d = ST_FULL;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q     <= ST_FULL;
      flush_req_o <= '0;
      lowv_ok_o   <= 1'b0;
      pend_q      <= 1'b0;
    end else begin
      state_q     <= state_d;
      flush_req_o <= req_d;
      lowv_ok_o   <= lowv_d;
      pend_q      <= pend_d;
    end
  end

  assign busy_o = !(state_q == ST_FULL || state_q == ST_SHRUNK);

  // R3
  req_onehot_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(flush_req_o));
  // R4
  req_on_disabled_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flush_req_o & way_en_o) == '0);
  // R5
  sleep_after_flush_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((way_sleep_o & ~$past(way_sleep_o)) != '0) |->
      ($past(flush_done_i) && ($past(flush_req_o) == (way_sleep_o & ~$past(way_sleep_o)))));
  // R6
  lowv_shrunk_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lowv_ok_o |-> (way_sleep_o == RETIRE_MASK && way_en_o == KEEP_MASK));
  // R7
  wake_after_lowv_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (($past(way_sleep_o) & ~way_sleep_o) != '0) |-> !$past(lowv_ok_o));
  // R11
  busy_lowv_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lowv_ok_o |-> !busy_o);
endmodule

// File: tb/way_shrink_ctrl_tb.sv
module way_shrink_ctrl_tb;
  localparam int NW     = 16;
  localparam int KEEP   = 2;
  localparam int SETTLE = 8;

  logic clk = 1'b0, rst_n = 1'b0, low = 1'b0, high = 1'b0, done = 1'b0;
  logic [NW-1:0] en, slp, req;
  logic busy, lowv;
  int n_chk = 0, n_err = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;

  way_shrink_ctrl #(.NUM_WAYS(NW), .KEEP_WAYS(KEEP), .SETTLE_CYCLES(SETTLE)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .low_act_i(low), .high_act_i(high),
    .flush_done_i(done), .way_en_o(en), .way_sleep_o(slp), .flush_req_o(req),
    .busy_o(busy), .lowv_ok_o(lowv)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  // ways KEEP..k-1
  function automatic logic [NW-1:0] span(int k);
    logic [NW-1:0] m = '0;
    for (int i = KEEP; i < k; i++) m[i] = 1'b1;
    return m;
  endfunction

  function automatic logic [NW-1:0] exp_en(int k);
    return ~span(k + 1);
  endfunction

  function automatic logic [NW-1:0] onehot(int k);
    logic [NW-1:0] m = '0;
    m[k] = 1'b1;
    return m;
  endfunction

  task automatic chk_full(input string tag);
    chk({tag, " en"}, en, 16'hFFFF);
    chk({tag, " sleep"}, slp, 16'h0000);
    chk({tag, " req"}, req, 16'h0000);
    chk({tag, " busy"}, busy, 1'b0);
    chk({tag, " lowv"}, lowv, 1'b0);
  endtask

  // from the edge where sleep clears: SETTLE edges to full enables
  task automatic expand_tail(input logic [NW-1:0] en_hold, input bit poke_low);
    chk("R7 sleep cleared", slp, 16'h0000);
    chk("R8 en held", en, en_hold);
    for (int i = 0; i < SETTLE - 1; i++) begin
      low = poke_low;
      step;
      chk("R8 en during settle", en, en_hold);
      chk("R11 busy during settle", busy, 1'b1);
      chk("R9 no req during expand", req, 16'h0000);
    end
    low = poke_low;
    step;
    low = 1'b0;
    chk("R8 en restored", en, 16'hFFFF);
    chk("R8 busy fell", busy, 1'b0);
    step;
    chk_full("R10 low ignored in expand");
  endtask

  // rev_way >= NW: no reversal
  task automatic run_shrink(input int rev_way, input bit same_cycle);
    int d;
    low = 1'b1;
    step;
    low = 1'b0;
    chk("R4 first en drop", en, exp_en(KEEP));
    chk("R4 no req yet", req, 16'h0000);
    chk("R11 busy shrink", busy, 1'b1);
    for (int k = KEEP; k < NW; k++) begin
      step;
      chk("R3 req order", req, onehot(k));
      chk("R4 en before req", en, exp_en(k));
      chk("R2 kept ways", en[KEEP-1:0], 2'b11);
      chk("R3 sleep so far", slp, span(k));
      chk("R6 lowv low", lowv, 1'b0);
      if (k == rev_way && !same_cycle) begin
        high = 1'b1;
        step;
        high = 1'b0;
        chk("R9 req held", req, onehot(k));
      end
      d = $urandom_range(0, 3);
      repeat (d) begin
        step;
        chk("R3 req waits", req, onehot(k));
      end
      done = 1'b1;
      if (k == rev_way && same_cycle) high = 1'b1;
      step;
      done = 1'b0;
      high = 1'b0;
      chk("R5 req cleared", req, 16'h0000);
      chk("R5 way asleep", slp, span(k + 1));
      if (k == rev_way) begin
        chk("R9 next way kept", en, exp_en(k));
        chk("R9 lowv stays low", lowv, 1'b0);
        chk("R9 busy", busy, 1'b1);
        step;
        chk("R9 no next req", req, 16'h0000);
        expand_tail(exp_en(k), 1'b0);
        return;
      end
      if (k == NW - 1) begin
        chk("R6 lowv raised", lowv, 1'b1);
        chk("R6 en shrunk", en, 16'h0003);
        chk("R6 sleep shrunk", slp, 16'hFFFC);
        chk("R6 busy idle", busy, 1'b0);
      end else begin
        chk("R5 next en drop", en, exp_en(k + 1));
      end
    end
  endtask

  task automatic expand_from_shrunk(input bit poke_low);
    high = 1'b1;
    step;
    high = 1'b0;
    chk("R7 lowv cleared first", lowv, 1'b0);
    chk("R7 still asleep", slp, 16'hFFFC);
    chk("R11 busy expand", busy, 1'b1);
    step;
    expand_tail(16'h0003, poke_low);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_err++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    @(negedge clk);
    chk_full("R1 in reset");
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    step;
    chk_full("R1 after reset");

    // R10: ignored stimulus in full state
    done = 1'b1; high = 1'b1;
    step;
    done = 1'b0; high = 1'b0;
    step;
    chk_full("R10 full ignores done/high");
    // R2: low and high together does nothing
    low = 1'b1; high = 1'b1;
    step;
    low = 1'b0; high = 1'b0;
    step;
    chk_full("R2 low+high ignored");

    // full shrink, then ignored stimulus in shrunk state
    run_shrink(NW, 1'b0);
    low = 1'b1; done = 1'b1;
    step;
    low = 1'b0; done = 1'b0;
    step;
    chk("R10 shrunk en", en, 16'h0003);
    chk("R10 shrunk sleep", slp, 16'hFFFC);
    chk("R10 shrunk req", req, 16'h0000);
    chk("R10 shrunk lowv", lowv, 1'b1);
    expand_from_shrunk(1'b1);

    // directed reversals at first and last way
    run_shrink(KEEP, 1'b1);
    run_shrink(NW - 1, 1'b1);
    run_shrink(NW - 1, 1'b0);
    run_shrink(7, 1'b0);

    // random mix
    for (int it = 0; it < 8; it++) begin
      int rv;
      rv = $urandom_range(KEEP, NW);
      run_shrink(rv, 1'($urandom_range(0, 1)));
      if (rv >= NW) expand_from_shrunk(1'b0);
      repeat ($urandom_range(0, 3)) step;
      chk_full("R1 back to full");
    end

    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule